// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer whose down-counter lives in its own slow clock domain, apart from the bus that configures it. Software cannot set enable bits. It steers the block only by writing 16-bit magic values to a key register. One key launches the counter, one services it so that the timeout starts again, and a third opens the prescaler and reload registers for writing. The all-zero key closes them, and so does any key the block does not recognise.

A prescaler setting or reload setting that is accepted on the bus side is carried into the counter domain by a toggle handshake. While that handshake is in flight, a busy bit in the status register stays set, and further writes to that register are refused. The counter takes up new settings the next time it loads. If software fails to service the counter in time, the block raises a reset request lasting one slow-clock cycle, reloads, and keeps counting. After it has been launched, only the counter-domain reset can stop it.

Top module: `kwdt_top`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0, the prescaler register (offset 0x04) reads 0, the reload register (offset 0x08) reads 0xFFF, and no reset request is raised while the counter has not been launched.
- R2: Writes to the prescaler and reload registers are ignored unless key 0x5555 was written to the key register (offset 0x00, bits 15:0) beforehand. Key 0x0000 closes them again.
- R3: A key value other than 0xCCCC, 0xAAAA, 0x5555 and 0x0000 closes the configuration registers and has no other effect. In particular it does not service a running counter.
- R4: An accepted prescaler write sets status bit 0 and an accepted reload write sets status bit 1. Each bit clears by itself once the counter domain has acknowledged the new value.
- R5: A write to the prescaler or reload register while its own status bit is set is ignored.
- R6: The prescaler code selects a divide ratio of 4 shifted left by the code. A written code above the largest legal code (6 for the default maximum ratio of 256) is stored as that largest code.
- R7: Key 0xCCCC launches the counter. Successive reset requests are then exactly (reload + 1) x (4 << prescaler) slow-clock cycles apart.
- R8: Each reset request is high for exactly one slow-clock cycle, after which the counter reloads and keeps counting.
- R9: Key 0xAAAA restarts a running timeout, so requests never appear while this key arrives more often than the timeout. The same key has no effect before launch.
- R10: Once launched, the counter cannot be stopped by any key. Only the counter-domain reset stops it.
- R11: When a service key reaches the counter in the same slow cycle as expiry, the service wins: no request is raised and the full timeout starts again.
- R12: New prescaler and reload settings are used from the counter's next load onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, bus domain |
| lclk | input | 1 | Slow counter clock |
| lrst_n | input | 1 | Synchronous active-low reset, counter domain |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| rst_req | output | 1 | One-cycle reset request, counter domain |

## Verification
Expiry and a service key can land on the same slow-clock cycle. The bench provokes this by issuing the service key a varying number of bus cycles after an observed request, one bus cycle per trial, across a span that straddles the next expiry. Each trial measures the gap from that request to the next one. Every gap must lie between one and two timeouts, and in the trial where the two events coincide the gap must be exactly two timeouts. A design in which expiry won would show a gap of one timeout there, and the largest gap in the sweep would fall one cycle short of two timeouts.

// File: rtl/kwdt_pkg.sv
// Shared constants and key decoding for the key-protected watchdog.
// Assumes a byte-addressed register bus with word-aligned registers.
package kwdt_pkg;

    localparam logic [15:0] KEY_LAUNCH = 16'hCCCC;
    localparam logic [15:0] KEY_SERVICE = 16'hAAAA;
    localparam logic [15:0] KEY_OPEN = 16'h5555;
    localparam logic [15:0] KEY_CLOSE = 16'h0000;

    localparam int OFS_KEY  = 0;
    localparam int OFS_PRE  = 4;
    localparam int OFS_RLD  = 8;
    localparam int OFS_STAT = 12;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_LAUNCH,
        CMD_SERVICE,
        CMD_OPEN,
        CMD_CLOSE
    } key_cmd_e;

    // Map a written key to its command; unknown keys close the registers.
    function automatic key_cmd_e decode_key(input logic [15:0] k);
        key_cmd_e c;
        case (k)
            KEY_LAUNCH:  c = CMD_LAUNCH;
            KEY_SERVICE: c = CMD_SERVICE;
            KEY_OPEN:    c = CMD_OPEN;
            default:     c = CMD_CLOSE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/kwdt_regs.sv
// Bus-side register file: key decoding, write lock, prescaler and reload
// holding registers, and status read-back.
// Assumes busy flags come from the transfer logic; a register is frozen
// while its busy flag is set, so the counter domain may sample it freely.
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32,
    parameter int PR_W     = 3,
    parameter int RL_W     = 12,
    parameter int MAX_CODE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pr_busy,
    input  logic              rl_busy,
    output logic [PR_W-1:0]   pr_q,
    output logic [RL_W-1:0]   rl_q,
    output logic              pr_load,
    output logic              rl_load,
    output logic              launch_evt,
    output logic              service_evt,
    output logic              unlocked
);

    localparam logic [RL_W-1:0] RL_RST = {RL_W{1'b1}};

    logic     wr_en;
    logic     hit_key;
    key_cmd_e cmd;
    logic [PR_W-1:0] pr_next;

    assign wr_en   = bus_sel & bus_wr;
    assign hit_key = wr_en && (bus_addr == ADDR_W'(OFS_KEY));

    // Decode the key only on a write to the key register.
    always_comb cmd = hit_key ? decode_key(bus_wdata[15:0]) : CMD_NONE;

    assign launch_evt  = (cmd == CMD_LAUNCH);
    assign service_evt = (cmd == CMD_SERVICE);

    // Accept a configuration write only when open and not in flight.
    assign pr_load = wr_en && (bus_addr == ADDR_W'(OFS_PRE)) && unlocked && !pr_busy;
    assign rl_load = wr_en && (bus_addr == ADDR_W'(OFS_RLD)) && unlocked && !rl_busy;

    // Clamp the prescaler code to the largest legal ratio.
    always_comb pr_next = (bus_wdata > DATA_W'(MAX_CODE)) ? PR_W'(MAX_CODE)
                                                          : bus_wdata[PR_W-1:0];

    // Write-protect state: opened by one key, closed by zero or unknown keys.
    always_ff @(posedge clk) begin
        if (!rst_n)                 unlocked <= 1'b0;
        else if (cmd == CMD_OPEN)   unlocked <= 1'b1;
        else if (cmd == CMD_CLOSE)  unlocked <= 1'b0;
    end

    // Prescaler holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)       pr_q <= '0;
        else if (pr_load) pr_q <= pr_next;
    end

    // Reload holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)       rl_q <= RL_RST;
        else if (rl_load) rl_q <= bus_wdata[RL_W-1:0];
    end

    // Read multiplexer; the key register reads as zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_PRE):  bus_rdata[PR_W-1:0] = pr_q;
            ADDR_W'(OFS_RLD):  bus_rdata[RL_W-1:0] = rl_q;
            ADDR_W'(OFS_STAT): bus_rdata[1:0]      = {rl_busy, pr_busy};
            default:           bus_rdata           = '0;
        endcase
    end

endmodule

// File: rtl/kwdt_cfg_xfer.sv
// Carries one configuration word from the bus domain into the counter
// domain with a toggle request and a toggle acknowledge.
// Assumes the source word stays stable while busy is high.
module kwdt_cfg_xfer #(
    parameter int            W       = 12,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] src,
    output logic         busy,
    input  logic         lclk,
    input  logic         lrst_n,
    output logic [W-1:0] dst
);

    logic              req_t;
    logic              ack_t;
    logic [STAGES-1:0] ack_s;
    logic [STAGES-1:0] req_s;
    logic              req_seen;

    // Flip the request toggle for each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)    req_t <= 1'b0;
        else if (load) req_t <= ~req_t;
    end

    // Bring the acknowledge toggle back into the bus domain.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_s <= '0;
        else        ack_s <= {ack_s[STAGES-2:0], ack_t};
    end

    assign busy = req_t ^ ack_s[STAGES-1];

    // Bring the request toggle into the counter domain.
    always_ff @(posedge lclk) begin
        if (!lrst_n) req_s <= '0;
        else         req_s <= {req_s[STAGES-2:0], req_t};
    end

    assign req_seen = req_s[STAGES-1];

    // Capture the word and answer the request.
    always_ff @(posedge lclk) begin
        if (!lrst_n) begin
            dst   <= RST_VAL;
            ack_t <= 1'b0;
        end else if (req_seen != ack_t) begin
            dst   <= src;
            ack_t <= req_seen;
        end
    end

endmodule

// File: rtl/kwdt_evt_sync.sv
// Moves a single-cycle bus-domain event into the counter domain as a
// single-cycle pulse. Assumes events are spaced further apart than the
// synchroniser latency, which holds for software key writes.
module kwdt_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic lclk,
    input  logic lrst_n,
    output logic pulse
);

    logic            tgl;
    logic [STAGES:0] sync_q;

    // Flip the toggle for each bus-side event.
    always_ff @(posedge clk) begin
        if (!rst_n)   tgl <= 1'b0;
        else if (evt) tgl <= ~tgl;
    end

    // Synchronise the toggle, keeping one extra stage for edge detection.
    always_ff @(posedge lclk) begin
        if (!lrst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-1:0], tgl};
    end

    assign pulse = sync_q[STAGES] ^ sync_q[STAGES-1];

endmodule

// File: rtl/kwdt_counter.sv
// Counter-domain timer: a power-of-two prescaler feeding a down-counter.
// Settings are latched at each load (launch, service or expiry). A service
// arriving in the expiry cycle suppresses the request.
module kwdt_counter #(
    parameter int PR_W  = 3,
    parameter int RL_W  = 12,
    parameter int DIV_W = 8
) (
    input  logic            lclk,
    input  logic            lrst_n,
    input  logic            launch_p,
    input  logic            service_p,
    input  logic [PR_W-1:0] pr_code,
    input  logic [RL_W-1:0] rl_val,
    output logic            rst_req,
    output logic            running
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last_q;
    logic [DIV_W-1:0] last_n;
    logic [DIV_W:0]   ratio_n;
    logic [RL_W-1:0]  cnt_q;
    logic             tick;
    logic             expire;
    logic             load;

    // Terminal value of the prescaler for the current setting.
    always_comb begin
        ratio_n = (DIV_W+1)'(4) << pr_code;
        last_n  = DIV_W'(ratio_n - 1'b1);
    end

    assign tick   = running && (div_q == last_q);
    assign expire = tick && (cnt_q == '0);
    assign load   = launch_p || (running && (service_p || expire));

    // Run flag: set by the launch key, cleared only by reset.
    always_ff @(posedge lclk) begin
        if (!lrst_n)       running <= 1'b0;
        else if (launch_p) running <= 1'b1;
    end

    // Prescaler and down-counter, reloaded on every load event.
    always_ff @(posedge lclk) begin
        if (!lrst_n) begin
            div_q  <= '0;
            last_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            div_q  <= '0;
            last_q <= last_n;
            cnt_q  <= rl_val;
        end else if (running) begin
            if (tick) begin
                div_q <= '0;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    // Request pulse on expiry unless a service or launch arrives with it.
    always_ff @(posedge lclk) begin
        if (!lrst_n) rst_req <= 1'b0;
        else         rst_req <= expire && !(service_p || launch_p);
    end

endmodule

// File: rtl/kwdt_top.sv
// Key-protected independent watchdog. The bus domain holds the registers;
// the counter runs on lclk. Configuration and key events cross by toggle
// synchronisers. Assumes MAX_RATIO is a power of two and at least 8.
module kwdt_top #(
    parameter int MAX_RATIO   = 256,
    parameter int RL_W        = 12,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lclk,
    input  logic              lrst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    localparam int MAX_CODE = $clog2(MAX_RATIO) - 2;
    localparam int PR_W     = $clog2(MAX_CODE + 1);
    localparam int DIV_W    = $clog2(MAX_RATIO);
    localparam logic [RL_W-1:0] RL_RST = {RL_W{1'b1}};

    logic [PR_W-1:0] pr_cfg;
    logic [RL_W-1:0] rl_cfg;
    logic [PR_W-1:0] pr_shadow;
    logic [RL_W-1:0] rl_shadow;
    logic            pr_load;
    logic            rl_load;
    logic            pr_busy;
    logic            rl_busy;
    logic            unlocked;
    logic            running;
    logic            launch_evt;
    logic            service_evt;
    logic [1:0]      evt_bus;
    logic [1:0]      evt_lck;

    kwdt_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PR_W     (PR_W),
        .RL_W     (RL_W),
        .MAX_CODE (MAX_CODE)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pr_busy     (pr_busy),
        .rl_busy     (rl_busy),
        .pr_q        (pr_cfg),
        .rl_q        (rl_cfg),
        .pr_load     (pr_load),
        .rl_load     (rl_load),
        .launch_evt  (launch_evt),
        .service_evt (service_evt),
        .unlocked    (unlocked)
    );

    kwdt_cfg_xfer #(
        .W       (PR_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_xfer_pr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (pr_load),
        .src    (pr_cfg),
        .busy   (pr_busy),
        .lclk   (lclk),
        .lrst_n (lrst_n),
        .dst    (pr_shadow)
    );

    kwdt_cfg_xfer #(
        .W       (RL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (RL_RST)
    ) u_xfer_rl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (rl_load),
        .src    (rl_cfg),
        .busy   (rl_busy),
        .lclk   (lclk),
        .lrst_n (lrst_n),
        .dst    (rl_shadow)
    );

    assign evt_bus = {service_evt, launch_evt};

    for (genvar g = 0; g < 2; g++) begin : g_evt
        kwdt_evt_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_bus[g]),
            .lclk   (lclk),
            .lrst_n (lrst_n),
            .pulse  (evt_lck[g])
        );
    end

    kwdt_counter #(
        .PR_W  (PR_W),
        .RL_W  (RL_W),
        .DIV_W (DIV_W)
    ) u_counter (
        .lclk      (lclk),
        .lrst_n    (lrst_n),
        .launch_p  (evt_lck[0]),
        .service_p (evt_lck[1]),
        .pr_code   (pr_shadow),
        .rl_val    (rl_shadow),
        .rst_req   (rst_req),
        .running   (running)
    );

endmodule

// File: rtl/kwdt_checker.sv
// Protocol checks for kwdt_top, bound to every instance of it.
module kwdt_checker
    import kwdt_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int PR_W     = 3,
    parameter int RL_W     = 12,
    parameter int MAX_CODE = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lclk,
    input logic              lrst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PR_W-1:0]   pr_cfg,
    input logic [RL_W-1:0]   rl_cfg,
    input logic              pr_busy,
    input logic              rl_busy,
    input logic              unlocked,
    input logic              running,
    input logic              rst_req
);

    logic wr_pr;
    logic wr_rl;

    assign wr_pr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_PRE));
    assign wr_rl = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_RLD));

    assert_locked_pr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pr && !unlocked) |=> $stable(pr_cfg));

    assert_locked_rl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rl && !unlocked) |=> $stable(rl_cfg));

    assert_busy_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pr && unlocked && !pr_busy) |=> pr_busy);

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rl && rl_busy) |=> $stable(rl_cfg));

    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pr_cfg <= PR_W'(MAX_CODE));

    assert_idle_quiet_R1: assert property (@(posedge lclk) disable iff (!lrst_n)
        !running |-> !rst_req);

    assert_single_pulse_R8: assert property (@(posedge lclk) disable iff (!lrst_n)
        rst_req |=> !rst_req);

    assert_never_stop_R10: assert property (@(posedge lclk) disable iff (!lrst_n)
        running |=> running);

endmodule

bind kwdt_top kwdt_checker #(
    .ADDR_W   (ADDR_W),
    .PR_W     (PR_W),
    .RL_W     (RL_W),
    .MAX_CODE (MAX_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lclk     (lclk),
    .lrst_n   (lrst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .pr_cfg   (pr_cfg),
    .rl_cfg   (rl_cfg),
    .pr_busy  (pr_busy),
    .rl_busy  (rl_busy),
    .unlocked (unlocked),
    .running  (running),
    .rst_req  (rst_req)
);

// File: tb/kwdt_top_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module kwdt_top_bench;

    localparam int CLK_PERIOD  = 10;
    localparam int LCLK_PERIOD = 40;
    localparam int A_KEY  = 0;
    localparam int A_PRE  = 4;
    localparam int A_RLD  = 8;
    localparam int A_STAT = 12;

    logic        clk = 1'b0;
    logic        lclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int lcount = 0;
    int pulse_cnt = 0;
    int last_t = 0;
    int prev_t = 0;
    int wide_cnt = 0;
    bit req_d = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(LCLK_PERIOD/2) lclk = ~lclk;

    kwdt_top u_kwdt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .lclk      (lclk),
        .lrst_n    (lrst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    // Request monitor: timestamps pulses in slow cycles and counts wide ones.
    always @(negedge lclk) begin
        lcount = lcount + 1;
        if (rst_req) begin
            pulse_cnt = pulse_cnt + 1;
            prev_t = last_t;
            last_t = lcount;
            if (req_d) wide_cnt = wide_cnt + 1;
        end
        req_d = rst_req;
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input int data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = 5'(addr); bus_wdata = 32'(data);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int addr, output int data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'(addr);
        #1 data = int'(bus_rdata);
        bus_sel = 1'b0;
    endtask

    // Poll status until both busy bits clear; returns polls used.
    task automatic wait_idle(output int polls);
        int s;
        polls = 0;
        bus_read(A_STAT, s);
        while (s != 0 && polls < 200) begin
            polls++;
            bus_read(A_STAT, s);
        end
    endtask

    task automatic wait_pulses(input int n);
        int target;
        target = pulse_cnt + n;
        wait (pulse_cnt >= target);
    endtask

    task automatic set_cfg(input int pr, input int rl);
        int p;
        bus_write(A_KEY, 32'h5555);
        bus_write(A_PRE, pr);
        wait_idle(p);
        bus_write(A_RLD, rl);
        wait_idle(p);
    endtask

    task automatic t_reset;
        int v;
        bus_read(A_STAT, v); check_eq("R1 status", v, 0);
        bus_read(A_PRE, v);  check_eq("R1 prescaler", v, 0);
        bus_read(A_RLD, v);  check_eq("R1 reload", v, 4095);
        bus_write(A_KEY, 32'hAAAA);
        repeat (400) @(negedge clk);
        check_eq("R1 R9 no request before launch", pulse_cnt, 0);
    endtask

    task automatic t_lock;
        int v, p;
        bus_write(A_PRE, 2);
        bus_read(A_PRE, v);  check_eq("R2 locked write ignored", v, 0);
        bus_read(A_STAT, v); check_eq("R2 locked write no busy", v, 0);
        bus_write(A_KEY, 32'h5555);
        bus_write(A_PRE, 2);
        wait_idle(p);
        bus_read(A_PRE, v);  check_eq("R2 open write taken", v, 2);
        bus_write(A_KEY, 32'h0000);
        bus_write(A_PRE, 1);
        bus_read(A_PRE, v);  check_eq("R2 relocked write ignored", v, 2);
    endtask

    task automatic t_badkey;
        int v;
        bus_write(A_KEY, 32'h5555);
        bus_write(A_KEY, 32'h1234);
        bus_write(A_RLD, 5);
        bus_read(A_RLD, v);  check_eq("R3 unknown key relocks", v, 4095);
    endtask

    task automatic t_busy;
        int v, p;
        bus_write(A_KEY, 32'h5555);
        bus_write(A_RLD, 3);
        bus_read(A_STAT, v); check_eq("R4 reload busy bit", v, 2);
        bus_write(A_RLD, 7);
        wait_idle(p);
        check_eq("R4 busy clears", (p < 200) ? 1 : 0, 1);
        bus_read(A_STAT, v); check_eq("R4 status idle", v, 0);
        bus_read(A_RLD, v);  check_eq("R5 write during busy ignored", v, 3);
        bus_write(A_PRE, 0);
        bus_read(A_STAT, v); check_eq("R4 prescaler busy bit", v, 1);
        bus_write(A_PRE, 5);
        wait_idle(p);
        bus_read(A_PRE, v);  check_eq("R5 prescaler write during busy ignored", v, 0);
    endtask

    task automatic t_sat;
        int v, p;
        bus_write(A_PRE, 7);
        wait_idle(p);
        bus_read(A_PRE, v);  check_eq("R6 code saturates", v, 6);
        bus_write(A_PRE, 0);
        wait_idle(p);
    endtask

    task automatic t_period;
        int n;
        bus_write(A_KEY, 32'hCCCC);
        wait_pulses(2);
        check_eq("R7 period rl=3 pr=0", last_t - prev_t, 16);
        n = pulse_cnt;
        wait_pulses(2);
        check_eq("R8 keeps counting", pulse_cnt - n, 2);
        check_eq("R8 one-cycle pulse", wide_cnt, 0);
        set_cfg(1, 2);
        wait_pulses(1);
        wait_pulses(1);
        check_eq("R12 new settings after load", last_t - prev_t, 24);
    endtask

    task automatic t_nostop;
        wait_pulses(1);
        bus_write(A_KEY, 32'h0000);
        bus_write(A_KEY, 32'h1234);
        bus_write(A_KEY, 32'h5555);
        bus_write(A_KEY, 32'h0000);
        wait_pulses(1);
        check_eq("R3 unknown key does not service", last_t - prev_t, 24);
        wait_pulses(1);
        check_eq("R10 still running", last_t - prev_t, 24);
    endtask

    task automatic t_service;
        int n0;
        wait_pulses(1);
        n0 = pulse_cnt;
        for (int i = 0; i < 10; i++) begin
            repeat (60) @(negedge clk);
            bus_write(A_KEY, 32'hAAAA);
        end
        check_eq("R9 serviced counter quiet", pulse_cnt, n0);
        wait_pulses(1);
        check_eq("R9 request resumes", pulse_cnt, n0 + 1);
    endtask

    task automatic t_collide;
        int t0, n, gap;
        bit seen_long, seen_short;
        seen_long = 0; seen_short = 0;
        set_cfg(0, 3);
        bus_write(A_KEY, 32'h0000);
        wait_pulses(2);
        for (int d = 24; d <= 72; d++) begin
            wait_pulses(1);
            t0 = last_t;
            n = pulse_cnt;
            repeat (d) @(negedge clk);
            bus_write(A_KEY, 32'hAAAA);
            wait (pulse_cnt > n);
            gap = last_t - t0;
            check_eq("R11 gap within one to two periods",
                     (gap >= 16 && gap <= 32) ? 1 : 0, 1);
            if (gap == 32) seen_long = 1;
            if (gap == 16) seen_short = 1;
        end
        check_eq("R11 coincident service suppresses request", int'(seen_long), 1);
        check_eq("R11 late service leaves request", int'(seen_short), 1);
    endtask

    initial begin
        repeat (4) @(negedge lclk);
        rst_n = 1'b1;
        lrst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_lock();
        t_badkey();
        t_busy();
        t_sat();
        t_period();
        t_nostop();
        t_service();
        t_collide();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule